// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the master side of a link to a 12-bit serial converter with two inputs. A single start pulse makes it run one complete frame. It lowers the chip select, drives sixteen serial clock periods, shifts an 8-bit control word out during the first half of the frame, and captures the converter's reply. When chip select goes high again it presents the 12-bit result with a one-cycle valid strobe. A flag reports when the four header bits of the reply are not all zero, which points to a framing or wiring fault.

The control word carries the channel choice, single- or dual-input operation and a two-bit power mode. The power mode has to go out with every frame. In power mode `00` the converter is powered only while chip select is low. For that mode the sequencer inserts a programmable wake-up wait after chip select falls and before any serial clock edge, so the sample is never taken while the converter is still powering up. In the other modes it clocks as soon as the setup half-period has passed. It accepts a new start in the cycle after the valid strobe, so back-to-back frames are possible.

The state machine has seven states:
- IDLE: chip select high, clock high. A start moves it to WAKE when the mode is `00` and the wait is nonzero, and to SETUP otherwise.
- WAKE: waits the programmed number of cycles, then moves to SETUP.
- SETUP: waits one half-period with chip select low and the clock high, then moves to LOW.
- LOW: the clock is low for one half-period. When it ends the clock rises and the data line is sampled. The machine goes to HIGH, or to HOLD after the sixteenth rise.
- HIGH: the clock is high for one half-period, then the machine returns to LOW.
- HOLD: waits one half-period after the last rise, then moves to DONE.
- DONE: chip select is high, the valid strobe is high and the result is updated. The machine then returns to IDLE.

Top module: `sadc_host`

## Requirements
- R1: While reset is held: cs_n_o=1, sclk_o=1, mosi_o=0, busy_o=0, valid_o=0, result_o=0 and lead_err_o=0.
- R2: A start_i seen while idle lowers cs_n_o on the next cycle and raises busy_o. busy_o stays high for as long as cs_n_o is low. A start_i seen while busy_o is high starts no further frame and does not change the frame in progress.
- R3: Each frame has exactly 16 rising edges of sclk_o. sclk_o is high whenever cs_n_o is high.
- R4: While cs_n_o is low, every low phase of sclk_o and every high phase between two edges lasts exactly div_i+1 clock cycles.
- R5: At the first 8 rising edges mosi_o carries the word {3'b000, dual_i, chan_i, 1'b0, pm_i[1], pm_i[0]}, most significant bit first, with pm_i[1] sent before pm_i[0]. At rising edges 9 to 16 it carries 0. During a frame mosi_o changes only in the cycle where sclk_o falls.
- R6: miso_i is sampled at each rising edge of sclk_o. result_o equals the bits sampled at rises 5 to 16, most significant bit first.
- R7: lead_err_o is 1 exactly when any bit sampled at rises 1 to 4 is 1. It is updated together with result_o.
- R8: The first falling edge of sclk_o comes exactly W+div_i+1 cycles after cs_n_o falls. W is wake_i when pm_i=2'b00 and 0 in every other mode.
- R9: cs_n_o rises exactly div_i+1 cycles after the 16th rising edge. valid_o is high only in the first cycle with cs_n_o high again. busy_o falls one cycle later.
- R10: If start_i is held high, the next frame begins at once: cs_n_o is high for exactly 2 cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | 1 | Input channel select bit for the control word |
| dual_i | input | 1 | Dual-input operation bit for the control word |
| pm_i | input | 2 | Power mode bits; 2'b00 is chip-select-controlled shutdown |
| div_i | input | DIV_W | Serial clock half-period minus one, in clock cycles |
| wake_i | input | WAKE_W | Wake-up wait in cycles, applied in power mode 2'b00 |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial control data to the converter |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | RES_BITS | Last conversion result |
| lead_err_o | output | 1 | Header bits of the last reply were not all zero |

## Verification
The hardest situation to reach from the ports is the interplay of timing windows: a wake-up wait, a long or minimal half-period, and a start request that arrives while a frame is already running or is held across frame boundaries. The stimulus draws the power mode, divider, wait and reply pattern at random from a fixed seed, and includes replies with nonzero header bits. It adds directed frames at the divider extremes, with the maximum wait, with start pulsed in mid-frame and with start held high across two frames. A bench-side converter model feeds each reply, and a cycle monitor times every edge against the configured values.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_DONE
    } sadc_state_e;

    localparam logic [1:0] PM_CS_SHUTDOWN = 2'b00;

    // Control word layout sent MSB first; power mode bits go last.
    function automatic logic [7:0] make_ctrl(input logic dual, input logic chan,
                                             input logic [1:0] pm);
        return {3'b000, dual, chan, 1'b0, pm[1], pm[0]};
    endfunction

endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4: a phase that has run out stays expired until reloaded
    a_r4_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && zero_o) |=> zero_o);

    // R4: a reload starts the phase at the requested length
    a_r4_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
    parameter int FRAME_BITS = 16,
    parameter int CTRL_BITS  = 8,
    parameter int BCNT_W     = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clear_i,
    input  logic [CTRL_BITS-1:0]  ctrl_i,
    input  logic                  rise_i,
    input  logic                  miso_i,
    output logic                  txbit_o,
    output logic [BCNT_W-1:0]     bitcnt_o,
    output logic [FRAME_BITS-1:0] rx_o
);

    localparam int PAD_BITS = FRAME_BITS - CTRL_BITS;

    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic [BCNT_W-1:0]     bitcnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q     <= '0;
            rx_q     <= '0;
            bitcnt_q <= '0;
        end else if (clear_i) begin
            tx_q     <= {ctrl_i, {PAD_BITS{1'b0}}};
            rx_q     <= '0;
            bitcnt_q <= '0;
        end else if (rise_i) begin
            tx_q     <= {tx_q[FRAME_BITS-2:0], 1'b0};
            rx_q     <= {rx_q[FRAME_BITS-2:0], miso_i};
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    assign txbit_o  = tx_q[FRAME_BITS-1];
    assign bitcnt_o = bitcnt_q;
    assign rx_o     = rx_q;

    // R3: never more rising edges than one frame holds
    a_r3_rise_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bitcnt_q <= BCNT_W'(FRAME_BITS));

    // R6: a new frame starts from an empty receive register
    a_r6_rx_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (rx_q == '0 && bitcnt_q == '0));

endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int WAKE_W     = 10,
    parameter int FRAME_BITS = 16,
    parameter int CTRL_BITS  = 8,
    parameter int RES_BITS   = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                chan_i,
    input  logic                dual_i,
    input  logic [1:0]          pm_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [WAKE_W-1:0]   wake_i,
    input  logic                miso_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                busy_o,
    output logic                valid_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                lead_err_o
);

    localparam int LEAD_BITS = FRAME_BITS - RES_BITS;
    localparam int CNT_W     = (DIV_W > WAKE_W) ? DIV_W : WAKE_W;
    localparam int BCNT_W    = $clog2(FRAME_BITS + 1);

    sadc_state_e state_q, state_d;

    logic [DIV_W-1:0]      div_q;
    logic [DIV_W-1:0]      div_sel;
    logic [WAKE_W-1:0]     wake_sel;
    logic [CNT_W-1:0]      load_val;
    logic                  phase_load;
    logic                  phase_zero;
    logic                  frame_clear;
    logic                  sclk_rise;
    logic                  txbit;
    logic [BCNT_W-1:0]     bitcnt;
    logic [FRAME_BITS-1:0] rx_word;
    logic                  wake_needed;

    logic                  cs_n_q, sclk_q, mosi_q, busy_q, valid_q, lead_err_q;
    logic [RES_BITS-1:0]   result_q;

    // Settings are taken from the ports in the cycle that accepts start.
    assign div_sel     = (state_q == ST_IDLE) ? div_i : div_q;
    assign wake_sel    = wake_i;
    assign wake_needed = (pm_i == PM_CS_SHUTDOWN) && (wake_i != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (frame_clear) begin
            div_q <= div_i;
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = wake_needed ? ST_WAKE : ST_SETUP;
            ST_WAKE:  if (phase_zero) state_d = ST_SETUP;
            ST_SETUP: if (phase_zero) state_d = ST_LOW;
            ST_LOW: begin
                if (phase_zero) begin
                    state_d = (bitcnt == BCNT_W'(FRAME_BITS - 1)) ? ST_HOLD : ST_HIGH;
                end
            end
            ST_HIGH:  if (phase_zero) state_d = ST_LOW;
            ST_HOLD:  if (phase_zero) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign phase_load  = (state_d != state_q);
    assign load_val    = (state_d == ST_WAKE) ? CNT_W'(wake_sel - 1'b1) : CNT_W'(div_sel);
    assign frame_clear = (state_q == ST_IDLE) && (state_d != ST_IDLE);
    assign sclk_rise   = (state_q == ST_LOW) && (state_d != ST_LOW);

    sadc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (phase_load),
        .load_val_i (load_val),
        .zero_o     (phase_zero)
    );

    sadc_shift #(
        .FRAME_BITS (FRAME_BITS),
        .CTRL_BITS  (CTRL_BITS),
        .BCNT_W     (BCNT_W)
    ) u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (frame_clear),
        .ctrl_i   (make_ctrl(dual_i, chan_i, pm_i)),
        .rise_i   (sclk_rise),
        .miso_i   (miso_i),
        .txbit_o  (txbit),
        .bitcnt_o (bitcnt),
        .rx_o     (rx_word)
    );

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_n_q     <= 1'b1;
            sclk_q     <= 1'b1;
            mosi_q     <= 1'b0;
            busy_q     <= 1'b0;
            valid_q    <= 1'b0;
            result_q   <= '0;
            lead_err_q <= 1'b0;
        end else begin
            cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_DONE);
            sclk_q  <= (state_d != ST_LOW);
            busy_q  <= (state_d != ST_IDLE);
            valid_q <= (state_d == ST_DONE);
            if ((state_d == ST_LOW) && (state_q != ST_LOW)) begin
                mosi_q <= txbit;
            end else if ((state_d == ST_IDLE) || (state_d == ST_DONE)) begin
                mosi_q <= 1'b0;
            end
            if (state_d == ST_DONE) begin
                result_q   <= rx_word[RES_BITS-1:0];
                lead_err_q <= |rx_word[FRAME_BITS-1:FRAME_BITS-LEAD_BITS];
            end
        end
    end

    assign cs_n_o     = cs_n_q;
    assign sclk_o     = sclk_q;
    assign mosi_o     = mosi_q;
    assign busy_o     = busy_q;
    assign valid_o    = valid_q;
    assign result_o   = result_q;
    assign lead_err_o = lead_err_q;

    // R3: clock rests high outside a frame
    a_r3_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> sclk_o);

    // R2: busy covers the whole chip-select window
    a_r2_busy_covers_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_o |-> busy_o);

    // R9: strobe is a single cycle
    a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R9: strobe coincides with chip select returning high
    a_r9_valid_on_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (cs_n_o && $past(!cs_n_o)));

    // R5: data out holds while the clock stays high inside a frame
    a_r5_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_o && !$past(cs_n_o) && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R9: busy falls right after the strobe
    a_r9_busy_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !busy_o);

endmodule

// File: tb/sadc_host_bench.sv
module sadc_host_bench;

    localparam int DIV_W  = 8;
    localparam int WAKE_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              start = 1'b0, chan = 1'b0, dual = 1'b0;
    logic [1:0]        pm = 2'b01;
    logic [DIV_W-1:0]  div = '0;
    logic [WAKE_W-1:0] wake = '0;
    logic              miso = 1'b0;
    logic              cs_n, sclk, mosi, busy, valid, lead_err;
    logic [11:0]       result;

    sadc_host u_sadc_host (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .dual_i(dual),
        .pm_i(pm), .div_i(div), .wake_i(wake), .miso_i(miso),
        .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .busy_o(busy), .valid_o(valid),
        .result_o(result), .lead_err_o(lead_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: next reply bit on each falling clock edge
    logic [15:0] slv_frame = '0;
    int          scnt = 0;
    always @(negedge sclk or negedge cs_n) begin
        if (!cs_n) begin
            if (sclk) begin
                scnt = 0;
            end else if (scnt < 16) begin
                miso = slv_frame[15-scnt];
                scnt++;
            end
        end
    end

    // Cycle monitor, sampled away from the active edge
    int cyc = 0, t_csf = 0, t_f1 = 0, t_lastrise = 0, t_csr = 0, t_busyf = 0;
    int nrise = 0, nfall = 0, bad_half = 0, bad_idle = 0, bad_mosi = 0;
    int nvalid_frame = 0, t_valid = 0, nframes = 0, gap = 0, last_edge = 0, exp_half = 1;
    logic [15:0] mosi_w = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0, prev_busy = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                t_csf = cyc; nrise = 0; nfall = 0; bad_half = 0; mosi_w = '0;
                nvalid_frame = 0; gap = cyc - t_csr; nframes++;
            end
            if (cs_n && !sclk) bad_idle++;
            if (!cs_n && !prev_sclk && sclk) begin
                nrise++;
                mosi_w = {mosi_w[14:0], mosi};
                if (cyc - last_edge != exp_half) bad_half++;
                last_edge = cyc;
                if (nrise == 16) t_lastrise = cyc;
            end
            if (!cs_n && prev_sclk && !sclk) begin
                nfall++;
                if (nfall == 1) t_f1 = cyc;
                else if (cyc - last_edge != exp_half) bad_half++;
                last_edge = cyc;
            end
            if (!cs_n && !prev_cs && (mosi != prev_mosi) && !(prev_sclk && !sclk)) bad_mosi++;
            if (!prev_cs && cs_n) t_csr = cyc;
            if (valid) begin nvalid_frame++; t_valid = cyc; end
            if (prev_busy && !busy) t_busyf = cyc;
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi; prev_busy = busy;
    end

    function automatic logic [7:0] exp_ctrl(input logic d, input logic c, input logic [1:0] p);
        return {3'b000, d, c, 1'b0, p[1], p[0]};
    endfunction

    task automatic wait_valid();
        @(negedge clk);
        while (!valid) @(negedge clk);
    endtask

    task automatic run_frame(input logic d, input logic c, input logic [1:0] p,
                             input int dv, input int wk, input logic [15:0] fr);
        int exp_wait;
        @(negedge clk);
        dual = d; chan = c; pm = p; div = DIV_W'(dv); wake = WAKE_W'(wk);
        slv_frame = fr; exp_half = dv + 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        repeat (3) @(negedge clk);
        #1;
        exp_wait = ((p == 2'b00) ? wk : 0) + dv + 1;
        chk(nrise == 16, "R3", "rising edges", nrise, 16);
        chk(bad_idle == 0, "R3", "clock low while deselected", bad_idle, 0);
        chk(bad_half == 0, "R4", "half-period mismatches", bad_half, 0);
        chk(mosi_w == {exp_ctrl(d, c, p), 8'h00}, "R5", "sent word", mosi_w, {exp_ctrl(d, c, p), 8'h00});
        chk(bad_mosi == 0, "R5", "data out moved off falling edge", bad_mosi, 0);
        chk(result == fr[11:0], "R6", "result", result, fr[11:0]);
        chk(lead_err == (|fr[15:12]), "R7", "header flag", lead_err, |fr[15:12]);
        chk(t_f1 - t_csf == exp_wait, "R8", "select to first fall", t_f1 - t_csf, exp_wait);
        chk(t_csr - t_lastrise == dv + 1, "R9", "last rise to deselect", t_csr - t_lastrise, dv + 1);
        chk(nvalid_frame == 1 && t_valid == t_csr, "R9", "strobe timing", t_valid, t_csr);
        chk(t_busyf == t_csr + 1, "R9", "busy fall", t_busyf, t_csr + 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed_init;
        int n0;
        seed_init = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1 && sclk == 1'b1 && mosi == 1'b0, "R1", "bus pins in reset",
            {cs_n, sclk, mosi}, 3'b110);
        chk(!busy && !valid && result == '0 && !lead_err, "R1", "status in reset",
            {busy, valid, lead_err, result}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corners
        run_frame(1'b0, 1'b0, 2'b01, 0, 0, 16'h0ABC);
        run_frame(1'b1, 1'b1, 2'b00, 0, 37, 16'h0FFF);
        run_frame(1'b0, 1'b1, 2'b00, 2, 0, 16'h0001);
        run_frame(1'b1, 1'b0, 2'b00, 1, 1023, 16'h9800);
        run_frame(1'b0, 1'b0, 2'b11, 255, 500, 16'h0555);
        run_frame(1'b1, 1'b1, 2'b10, 3, 900, 16'h1000);

        // R2: start while busy is ignored
        n0 = nframes;
        @(negedge clk);
        dual = 1'b1; chan = 1'b0; pm = 2'b01; div = 8'd2; wake = '0;
        exp_half = 3; slv_frame = 16'h0321; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        chk(busy == 1'b1, "R2", "busy inside frame", busy, 1);
        pm = 2'b11; chan = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        repeat (20) @(negedge clk);
        chk(nframes == n0 + 1, "R2", "frames after mid-frame start", nframes - n0, 1);
        chk(mosi_w == {exp_ctrl(1'b1, 1'b0, 2'b01), 8'h00}, "R2", "word of running frame",
            mosi_w, {exp_ctrl(1'b1, 1'b0, 2'b01), 8'h00});
        chk(result == 12'h321, "R2", "result of running frame", result, 12'h321);

        // R10: start held high gives back-to-back frames
        n0 = nframes;
        @(negedge clk);
        dual = 1'b0; chan = 1'b1; pm = 2'b01; div = 8'd1; exp_half = 2;
        slv_frame = 16'h0777; start = 1'b1;
        wait_valid();
        while (valid) @(negedge clk);
        wait_valid();
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(nframes == n0 + 2, "R10", "frames with start held", nframes - n0, 2);
        chk(gap == 2, "R10", "deselect gap between frames", gap, 2);

        // Random frames
        for (int i = 0; i < 24; i++) begin
            logic [15:0] fr;
            logic [1:0]  p;
            fr = 16'($urandom);
            if (($urandom % 4) != 0) fr[15:12] = 4'h0;
            p = 2'($urandom);
            run_frame(1'($urandom), 1'($urandom), p, int'($urandom % 16),
                      int'($urandom % 300), fr);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule